// File: doc/BRIEF.md
# RDMA Write Header Field Generator

This block computes the per-packet variable fields of an unreliable-connection RDMA write packet stream carried in IP/UDP. It watches the handshake of a packet stream and, each time a packet begins, registers a fresh set of header fields: IP total length, UDP length, transport opcode, packet sequence number, remote virtual address, DMA length and immediate data. A separate serialiser places these fields into the outgoing header.

Packets are grouped into messages of a configured size. Internal counters track the packet position inside the current message and the message index. The position selects the write opcode, and the message index steps the remote address by one DMA length per message, wrapping after a configured number of messages. The immediate field is enabled or disabled at build time. When it is enabled, it carries either a configured value or the message index.

The block only observes the stream. It never drives back-pressure, so a start-of-packet counts only in a cycle where the producer's valid and the consumer's ready are both high. The configuration inputs must stay stable between resets. The DMA length input is expected to equal block length times packets per message.

Top module: `rdma_wr_hdr_gen`

## Requirements
- R1: A packet start is a clock edge with `snk_valid`, `snk_ready` and `snk_sop` all high. At that edge every `hdr_*` output takes the fields of the new packet. At all other edges every output holds its value.
- R2: A synchronous reset (`rst` high at an edge) sets every `hdr_*` output to zero and clears the packet, position and message counters.
- R3: `hdr_psn` is 0 for the first packet after reset and rises by one for each later packet.
- R4: In a message of several packets, the first packet carries opcode 0x26 and the middle packets carry 0x27. The last packet carries 0x28 when the immediate field is disabled.
- R5: With the immediate field enabled, the last packet of a message of several packets carries 0x29.
- R6: When packets per message is 1 (or 0, treated as 1), every packet carries 0x2A, or 0x2B with the immediate field enabled.
- R7: `hdr_vaddr` equals `cfg_start_addr` + (m mod N) × `cfg_dma_len`, modulo 2^64. Here m = packet count / packets per message, and N is `cfg_nof_msg`, with 0 treated as 1.
- R8: `hdr_dma_len` equals `cfg_dma_len`.
- R9: `hdr_udp_len` = 8 + H + `cfg_block_len` and `hdr_ip_len` = 20 + `hdr_udp_len`. H is 36 bytes with the immediate field enabled and 32 bytes without it.
- R10: `hdr_imm` is zero when the immediate field is disabled. When it is enabled, it is `cfg_imm_data`, or (m mod N) if the message-index option is set.
- R11: An edge at which `snk_sop` is high but `snk_valid` or `snk_ready` is low leaves all outputs unchanged and does not advance any counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| snk_valid | input | 1 | Observed stream valid |
| snk_ready | input | 1 | Observed stream ready |
| snk_sop | input | 1 | Observed stream start-of-packet |
| cfg_block_len | input | 16 | Payload bytes per packet |
| cfg_pkts_per_msg | input | CNT_W | Packets per message |
| cfg_nof_msg | input | CNT_W | Messages before the address wraps |
| cfg_dma_len | input | 32 | Bytes per message |
| cfg_start_addr | input | 64 | Remote address of message 0 |
| cfg_imm_data | input | 32 | Configured immediate value |
| hdr_ip_len | output | 16 | IP total length |
| hdr_udp_len | output | 16 | UDP length |
| hdr_opcode | output | 8 | Transport opcode |
| hdr_psn | output | 32 | Packet sequence number |
| hdr_vaddr | output | 64 | Remote virtual address |
| hdr_dma_len | output | 32 | DMA length field |
| hdr_imm | output | 32 | Immediate data field |

## Verification
The range checks on the position and message counters assume that packets per message and the message count change only while reset is held. Without that, a shrinking limit could leave a counter above its new bound. The bench therefore raises reset first, changes the configuration while reset is high, and only then releases it. It also keeps `cfg_dma_len` equal to block length times packets per message. The ignored-strobe cases drop valid or ready for single cycles, which the hold property covers without extra assumptions.

// File: rtl/rdma_wr_hdr_pkg.sv
package rdma_wr_hdr_pkg;
  localparam int LEN_W  = 16;
  localparam int PSN_W  = 32;
  localparam int OP_W   = 8;
  localparam int ADDR_W = 64;
  localparam int DMA_W  = 32;
  localparam int IMM_W  = 32;

  localparam int IP_HDR_BYTES  = 20;
  localparam int UDP_HDR_BYTES = 8;
  localparam int BTH_BYTES     = 12;
  localparam int RETH_BYTES    = 16;
  localparam int IMMDT_BYTES   = 4;
  localparam int ICRC_BYTES    = 4;

  typedef enum logic [OP_W-1:0] {
    OP_WR_FIRST    = 8'h26,
    OP_WR_MIDDLE   = 8'h27,
    OP_WR_LAST     = 8'h28,
    OP_WR_LAST_IMM = 8'h29,
    OP_WR_ONLY     = 8'h2A,
    OP_WR_ONLY_IMM = 8'h2B
  } wr_op_e;

  function automatic int transport_hdr_bytes(bit with_imm);
    return ICRC_BYTES + BTH_BYTES + RETH_BYTES + (with_imm ? IMMDT_BYTES : 0);
  endfunction
endpackage

// File: rtl/rdma_wr_seqctr.sv
module rdma_wr_seqctr
  import rdma_wr_hdr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic [CNT_W-1:0]  pkts_per_msg,
  input  logic [CNT_W-1:0]  nof_msg,
  input  logic [DMA_W-1:0]  dma_len,
  output logic [CNT_W-1:0]  ppm_eff,
  output logic [CNT_W-1:0]  pos_q,
  output logic [CNT_W-1:0]  msg_q,
  output logic [PSN_W-1:0]  psn_q,
  output logic [ADDR_W-1:0] addr_off_q
);
  logic [CNT_W-1:0] nof_eff;
  logic             pos_last;
  logic             msg_last;

  always_comb begin
    ppm_eff  = (pkts_per_msg == '0) ? CNT_W'(1) : pkts_per_msg;
    nof_eff  = (nof_msg == '0) ? CNT_W'(1) : nof_msg;
    pos_last = (pos_q >= ppm_eff - CNT_W'(1));
    msg_last = (msg_q >= nof_eff - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q      <= '0;
      msg_q      <= '0;
      psn_q      <= '0;
      addr_off_q <= '0;
    end else if (step) begin
      psn_q <= psn_q + PSN_W'(1);
      if (pos_last) begin
        pos_q <= '0;
        if (msg_last) begin
          msg_q      <= '0;
          addr_off_q <= '0;
        end else begin
          msg_q      <= msg_q + CNT_W'(1);
          addr_off_q <= addr_off_q + ADDR_W'(dma_len);
        end
      end else begin
        pos_q <= pos_q + CNT_W'(1);
      end
    end
  end

  // R3
  psn_step_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> psn_q == $past(psn_q) + PSN_W'(1));

  // R4
  pos_range_chk: assert property (@(posedge clk) disable iff (rst)
    pos_q < ppm_eff);

  // R7
  msg_range_chk: assert property (@(posedge clk) disable iff (rst)
    msg_q < nof_eff);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(psn_q) && $stable(pos_q) && $stable(msg_q));
endmodule

// File: rtl/rdma_wr_opsel.sv
module rdma_wr_opsel
  import rdma_wr_hdr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter bit IMM_EN = 1'b1
) (
  input  logic [CNT_W-1:0] pos,
  input  logic [CNT_W-1:0] ppm_eff,
  output wr_op_e           op
);
  logic is_first;
  logic is_last;

  always_comb begin
    is_first = (pos == '0);
    is_last  = (pos >= ppm_eff - CNT_W'(1));
    if (is_first && is_last)
      op = IMM_EN ? OP_WR_ONLY_IMM : OP_WR_ONLY;
    else if (is_first)
      op = OP_WR_FIRST;
    else if (is_last)
      op = IMM_EN ? OP_WR_LAST_IMM : OP_WR_LAST;
    else
      op = OP_WR_MIDDLE;
  end
endmodule

// File: rtl/rdma_wr_lencalc.sv
module rdma_wr_lencalc
  import rdma_wr_hdr_pkg::*;
#(
  parameter bit IMM_EN = 1'b1
) (
  input  logic [LEN_W-1:0] block_len,
  output logic [LEN_W-1:0] udp_len,
  output logic [LEN_W-1:0] ip_len
);
  localparam int HDR_BYTES = transport_hdr_bytes(IMM_EN);
  localparam logic [LEN_W-1:0] UDP_ADD = LEN_W'(UDP_HDR_BYTES + HDR_BYTES);
  localparam logic [LEN_W-1:0] IP_ADD  = LEN_W'(IP_HDR_BYTES + UDP_HDR_BYTES + HDR_BYTES);

  always_comb begin
    udp_len = block_len + UDP_ADD;
    ip_len  = block_len + IP_ADD;
  end
endmodule

// File: rtl/rdma_wr_hdr_gen.sv
module rdma_wr_hdr_gen
  import rdma_wr_hdr_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter bit IMM_EN       = 1'b1,
  parameter bit IMM_FROM_MSG = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snk_valid,
  input  logic              snk_ready,
  input  logic              snk_sop,
  input  logic [LEN_W-1:0]  cfg_block_len,
  input  logic [CNT_W-1:0]  cfg_pkts_per_msg,
  input  logic [CNT_W-1:0]  cfg_nof_msg,
  input  logic [DMA_W-1:0]  cfg_dma_len,
  input  logic [ADDR_W-1:0] cfg_start_addr,
  input  logic [IMM_W-1:0]  cfg_imm_data,
  output logic [LEN_W-1:0]  hdr_ip_len,
  output logic [LEN_W-1:0]  hdr_udp_len,
  output logic [OP_W-1:0]   hdr_opcode,
  output logic [PSN_W-1:0]  hdr_psn,
  output logic [ADDR_W-1:0] hdr_vaddr,
  output logic [DMA_W-1:0]  hdr_dma_len,
  output logic [IMM_W-1:0]  hdr_imm
);
  logic              pkt_start;
  logic [CNT_W-1:0]  ppm_eff;
  logic [CNT_W-1:0]  pos_q;
  logic [CNT_W-1:0]  msg_q;
  logic [PSN_W-1:0]  psn_q;
  logic [ADDR_W-1:0] addr_off_q;
  wr_op_e            op_next;
  logic [LEN_W-1:0]  udp_next;
  logic [LEN_W-1:0]  ip_next;
  logic [IMM_W-1:0]  imm_next;

  assign pkt_start = snk_valid && snk_ready && snk_sop;

  rdma_wr_seqctr #(.CNT_W(CNT_W)) u_seqctr (
    .clk          (clk),
    .rst          (rst),
    .step         (pkt_start),
    .pkts_per_msg (cfg_pkts_per_msg),
    .nof_msg      (cfg_nof_msg),
    .dma_len      (cfg_dma_len),
    .ppm_eff      (ppm_eff),
    .pos_q        (pos_q),
    .msg_q        (msg_q),
    .psn_q        (psn_q),
    .addr_off_q   (addr_off_q)
  );

  rdma_wr_opsel #(.CNT_W(CNT_W), .IMM_EN(IMM_EN)) u_opsel (
    .pos     (pos_q),
    .ppm_eff (ppm_eff),
    .op      (op_next)
  );

  rdma_wr_lencalc #(.IMM_EN(IMM_EN)) u_lencalc (
    .block_len (cfg_block_len),
    .udp_len   (udp_next),
    .ip_len    (ip_next)
  );

  always_comb begin
    if (!IMM_EN)
      imm_next = '0;
    else
      imm_next = IMM_FROM_MSG ? IMM_W'(msg_q) : cfg_imm_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_ip_len  <= '0;
      hdr_udp_len <= '0;
      hdr_opcode  <= '0;
      hdr_psn     <= '0;
      hdr_vaddr   <= '0;
      hdr_dma_len <= '0;
      hdr_imm     <= '0;
    end else if (pkt_start) begin
      hdr_ip_len  <= ip_next;
      hdr_udp_len <= udp_next;
      hdr_opcode  <= op_next;
      hdr_psn     <= psn_q;
      hdr_vaddr   <= cfg_start_addr + addr_off_q;
      hdr_dma_len <= cfg_dma_len;
      hdr_imm     <= imm_next;
    end
  end

  // R1
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pkt_start |=> $stable(hdr_psn) && $stable(hdr_opcode) && $stable(hdr_vaddr)
                   && $stable(hdr_imm) && $stable(hdr_ip_len));

  // R6
  only_op_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_start && cfg_pkts_per_msg <= CNT_W'(1)) |=>
      (hdr_opcode == OP_WR_ONLY || hdr_opcode == OP_WR_ONLY_IMM));

  // R9
  len_rel_chk: assert property (@(posedge clk) disable iff (rst)
    pkt_start |=> hdr_ip_len == hdr_udp_len + LEN_W'(IP_HDR_BYTES));

  // R4
  first_op_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_start && pos_q == '0 && ppm_eff > CNT_W'(1)) |=> hdr_opcode == OP_WR_FIRST);
endmodule

// File: tb/test_rdma_wr_hdr_gen.sv
module test_rdma_wr_hdr_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic snk_valid = 1'b0, snk_ready = 1'b0, snk_sop = 1'b0;
  logic [15:0] cfg_block_len = '0;
  logic [15:0] cfg_ppm = 16'd1, cfg_nof = 16'd1;
  logic [31:0] cfg_dma = '0;
  logic [63:0] cfg_start = '0;
  logic [31:0] cfg_imm = 32'h89AB_CDEF;

  logic [15:0] o_ip [3];
  logic [15:0] o_udp[3];
  logic [7:0]  o_op [3];
  logic [31:0] o_psn[3];
  logic [63:0] o_va [3];
  logic [31:0] o_dma[3];
  logic [31:0] o_imm[3];

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rdma_wr_hdr_gen #(.CNT_W(16), .IMM_EN(1'b0), .IMM_FROM_MSG(1'b0)) i_rdma_wr_hdr_gen (
    .clk(clk), .rst(rst), .snk_valid(snk_valid), .snk_ready(snk_ready), .snk_sop(snk_sop),
    .cfg_block_len(cfg_block_len), .cfg_pkts_per_msg(cfg_ppm), .cfg_nof_msg(cfg_nof),
    .cfg_dma_len(cfg_dma), .cfg_start_addr(cfg_start), .cfg_imm_data(cfg_imm),
    .hdr_ip_len(o_ip[0]), .hdr_udp_len(o_udp[0]), .hdr_opcode(o_op[0]), .hdr_psn(o_psn[0]),
    .hdr_vaddr(o_va[0]), .hdr_dma_len(o_dma[0]), .hdr_imm(o_imm[0]));

  rdma_wr_hdr_gen #(.CNT_W(16), .IMM_EN(1'b1), .IMM_FROM_MSG(1'b0)) i_rdma_wr_hdr_gen_cfg (
    .clk(clk), .rst(rst), .snk_valid(snk_valid), .snk_ready(snk_ready), .snk_sop(snk_sop),
    .cfg_block_len(cfg_block_len), .cfg_pkts_per_msg(cfg_ppm), .cfg_nof_msg(cfg_nof),
    .cfg_dma_len(cfg_dma), .cfg_start_addr(cfg_start), .cfg_imm_data(cfg_imm),
    .hdr_ip_len(o_ip[1]), .hdr_udp_len(o_udp[1]), .hdr_opcode(o_op[1]), .hdr_psn(o_psn[1]),
    .hdr_vaddr(o_va[1]), .hdr_dma_len(o_dma[1]), .hdr_imm(o_imm[1]));

  rdma_wr_hdr_gen #(.CNT_W(16), .IMM_EN(1'b1), .IMM_FROM_MSG(1'b1)) i_rdma_wr_hdr_gen_msg (
    .clk(clk), .rst(rst), .snk_valid(snk_valid), .snk_ready(snk_ready), .snk_sop(snk_sop),
    .cfg_block_len(cfg_block_len), .cfg_pkts_per_msg(cfg_ppm), .cfg_nof_msg(cfg_nof),
    .cfg_dma_len(cfg_dma), .cfg_start_addr(cfg_start), .cfg_imm_data(cfg_imm),
    .hdr_ip_len(o_ip[2]), .hdr_udp_len(o_udp[2]), .hdr_opcode(o_op[2]), .hdr_psn(o_psn[2]),
    .hdr_vaddr(o_va[2]), .hdr_dma_len(o_dma[2]), .hdr_imm(o_imm[2]));

  task automatic chk(input string what, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", what, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_op(input bit imm, input int pos, input int ppm);
    if (ppm <= 1) return imm ? 8'h2B : 8'h2A;
    if (pos == 0) return 8'h26;
    if (pos == ppm - 1) return imm ? 8'h29 : 8'h28;
    return 8'h27;
  endfunction

  task automatic apply_cfg(input int ppm, input int nof, input int blk,
                           input logic [63:0] start);
    @(negedge clk);
    rst = 1'b1;
    snk_valid = 1'b0; snk_ready = 1'b0; snk_sop = 1'b0;
    cfg_ppm = 16'(ppm); cfg_nof = 16'(nof); cfg_block_len = 16'(blk);
    cfg_dma = 32'(blk * ((ppm == 0) ? 1 : ppm)); cfg_start = start;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send_pkt(input int gap);
    snk_valid = 1'b1; snk_ready = 1'b1; snk_sop = 1'b1;
    @(negedge clk);
    snk_valid = 1'b0; snk_ready = 1'b0; snk_sop = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic check_pkt(input int p, input int ppm, input int nof);
    int ppe = (ppm == 0) ? 1 : ppm;
    int nfe = (nof == 0) ? 1 : nof;
    int m = (p / ppe) % nfe;
    int pos = p % ppe;
    for (int k = 0; k < 3; k++) begin
      int hb = (k == 0) ? 32 : 36;
      logic [31:0] ei = (k == 0) ? 32'h0 : ((k == 1) ? cfg_imm : 32'(m));
      chk($sformatf("R3 psn inst%0d pkt%0d", k, p), 64'(o_psn[k]), 64'(p));
      chk($sformatf("R4/R5/R6 opcode inst%0d pkt%0d", k, p), 64'(o_op[k]),
          64'(exp_op(k != 0, pos, ppe)));
      chk($sformatf("R7 vaddr inst%0d pkt%0d", k, p), o_va[k],
          cfg_start + 64'(m) * 64'(cfg_dma));
      chk($sformatf("R8 dma inst%0d pkt%0d", k, p), 64'(o_dma[k]), 64'(cfg_dma));
      chk($sformatf("R9 udp inst%0d pkt%0d", k, p), 64'(o_udp[k]),
          64'(16'(8 + hb + int'(cfg_block_len))));
      chk($sformatf("R9 ip inst%0d pkt%0d", k, p), 64'(o_ip[k]),
          64'(16'(28 + hb + int'(cfg_block_len))));
      chk($sformatf("R10 imm inst%0d pkt%0d", k, p), 64'(o_imm[k]), 64'(ei));
    end
  endtask

  task automatic run_seq(input int ppm, input int nof, input int n, input int blk,
                         input logic [63:0] start, input int gap);
    apply_cfg(ppm, nof, blk, start);
    for (int p = 0; p < n; p++) begin
      send_pkt(gap);
      check_pkt(p, ppm, nof);
    end
  endtask

  task automatic test_reset();
    apply_cfg(3, 2, 256, 64'h1234);
    for (int k = 0; k < 3; k++) begin
      chk("R2 reset psn", 64'(o_psn[k]), 64'h0);
      chk("R2 reset opcode", 64'(o_op[k]), 64'h0);
      chk("R2 reset vaddr", o_va[k], 64'h0);
      chk("R2 reset ip_len", 64'(o_ip[k]), 64'h0);
      chk("R2 reset imm", 64'(o_imm[k]), 64'h0);
    end
  endtask

  task automatic test_multi_back_to_back();
    run_seq(3, 2, 8, 256, 64'h0000_1000_0000_0000, 0);
  endtask

  task automatic test_multi_gaps_addr_wrap();
    run_seq(4, 3, 13, 64, 64'hFFFF_FFFF_FFFF_FF00, 2);
  endtask

  task automatic test_single_pkt_msgs();
    run_seq(1, 3, 5, 1024, 64'h0000_0000_8000_0000, 1);
  endtask

  task automatic test_zero_msgs_and_ppm();
    run_seq(2, 0, 5, 128, 64'h40, 0);
    run_seq(0, 2, 3, 32, 64'h80, 0);
  endtask

  task automatic test_ignored_sop();
    logic [7:0] op_before;
    apply_cfg(3, 2, 100, 64'h2000);
    send_pkt(0);
    send_pkt(0);
    op_before = o_op[0];
    snk_valid = 1'b1; snk_ready = 1'b0; snk_sop = 1'b1;
    @(negedge clk);
    chk("R11 psn held (ready low)", 64'(o_psn[0]), 64'd1);
    snk_valid = 1'b0; snk_ready = 1'b1; snk_sop = 1'b1;
    @(negedge clk);
    chk("R11 psn held (valid low)", 64'(o_psn[0]), 64'd1);
    snk_valid = 1'b1; snk_ready = 1'b1; snk_sop = 1'b0;
    @(negedge clk);
    chk("R1 psn held (sop low)", 64'(o_psn[0]), 64'd1);
    chk("R1 opcode held", 64'(o_op[0]), 64'(op_before));
    snk_valid = 1'b0; snk_ready = 1'b0;
    send_pkt(0);
    check_pkt(2, 3, 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_multi_back_to_back();
    test_multi_gaps_addr_wrap();
    test_single_pkt_msgs();
    test_zero_msgs_and_ppm();
    test_ignored_sop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule